// File: doc/BRIEF.md
# Multi-Operand Counter-Tree Adder

This block adds N_OPS unsigned integers of OP_W bits each and returns their exact total. The operands are first treated as a heap of rows. Each compression level splits the rows into groups. Every group is reduced by a strip of generalized counter cells. Each cell weighs bits from two adjacent columns and writes a 4-bit count. The levels repeat until two rows remain, and one two-input carry-propagate adder then produces the result.

Every compression level has a register stage. A per-level parameter bit either uses that stage or makes the level transparent. One build can therefore run fully combinational, fully pipelined, or anywhere in between. A valid strobe travels with the data, so the output strobe follows the input strobe by exactly the number of registered levels. Operands are packed on a flat bus, with operand j in bits [j*OP_W +: OP_W].

Top module: `gpc_adder_tree`

## Requirements
- R1: When `out_vld` is high, `out_sum` equals the exact unsigned total of the operands that entered together. It is OP_W + clog2(N_OPS) bits wide, so even all-ones operands never overflow.
- R2: Every compression level preserves the arithmetic total of its rows, modulo 2^(result width). The last level leaves exactly two rows, and their sum is the result.
- R3: A counter cell takes five bits of one column (weight 1) and five bits of the next column (weight 2). It outputs their weighted count as a 4-bit binary number, formed by a 15-input ones counter that sees each weight-2 bit twice.
- R4: Each level takes rows in groups of five, and each group becomes two rows. A last group of three or four rows uses the same cells with the missing inputs forced to zero. A last group of one or two rows is passed to the next level unchanged.
- R5: The number of levels is the number of regroupings needed to reach two rows; eight operands take two levels. The latency in cycles equals the number of levels whose register bit in `LVL_REG` is set (bit i belongs to level i).
- R6: Each input cycle with `in_vld` high produces exactly one output cycle with `out_vld` high. Back-to-back inputs give back-to-back results in order, and no output strobe appears without an input.
- R7: A synchronous active-high `rst` clears every valid stage. Anything in flight is dropped, and `out_vld` stays low until a new input has crossed the pipeline.
- R8: With every register bit clear, the tree is purely combinational. `out_vld` and `out_sum` follow the inputs within the same cycle.
- R9: In a registered level, operands presented while `in_vld` is low are not captured. A fully registered tree keeps its last result on `out_sum` and keeps `out_vld` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand set is valid this cycle |
| in_ops | input | N_OPS*OP_W | Packed operands, operand j at bits [j*OP_W +: OP_W] |
| out_vld | output | 1 | Result is valid this cycle |
| out_sum | output | OP_W+clog2(N_OPS) | Total of the operand set |

## Verification
The hardest situation to reach is a final group of three or four rows, where cells run with some inputs tied to zero. The case must also put carries across every column pair, which random data seldom does at full strength. Eight operands make the first level split into one full group and one group of three. The stimulus then lights only the last three operands, sets every operand to all ones, and repeats a two-bit pattern in every operand so that each cell sees both weights at once. A reset is also raised while a set is halfway through the pipeline. This shows that the set is dropped and that a later set still comes out with the right latency.

// File: rtl/gpc_tree_pkg.sv
package gpc_tree_pkg;

  // bits taken from each of the two columns a cell covers
  localparam int CELL_COL_BITS = 5;
  // ones-counter size and its output width
  localparam int CELL_CTR_IN   = 3 * CELL_COL_BITS;
  localparam int CELL_OUT_W    = $clog2(CELL_CTR_IN + 1);
  // upper bound on tree depth, sizes the register-select mask
  localparam int MAX_LVL       = 8;

  // rows left after one level of grouping
  function automatic int rows_next(input int r);
    int full;
    int rem;
    full = r / CELL_COL_BITS;
    rem  = r % CELL_COL_BITS;
    if (rem >= 3) return 2 * full + 2;
    return 2 * full + rem;
  endfunction

  // rows present at the input of a given level
  function automatic int rows_at(input int n, input int lvl);
    int r;
    r = n;
    for (int i = 0; i < lvl; i++) r = rows_next(r);
    return r;
  endfunction

  // levels needed to reach two rows
  function automatic int tree_levels(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = rows_next(r);
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/gpc_cell.sv
module gpc_cell
  import gpc_tree_pkg::*;
(
  input  logic [CELL_COL_BITS-1:0] lo_bits,
  input  logic [CELL_COL_BITS-1:0] hi_bits,
  output logic [CELL_OUT_W-1:0]    count
);

  // weight-2 bits feed two counter inputs each
  logic [CELL_CTR_IN-1:0] ctr_in;
  assign ctr_in = {hi_bits, hi_bits, lo_bits};

  always_comb begin
    count = '0;
    for (int i = 0; i < CELL_CTR_IN; i++) begin
      count = count + CELL_OUT_W'(ctr_in[i]);
    end
  end

  // R3: count equals the weighted total of the two columns
  always_comb begin
    a_r3_cell_weight: assert (count == CELL_OUT_W'($countones(lo_bits))
                                      + CELL_OUT_W'(2 * $countones(hi_bits)));
  end

endmodule

// File: rtl/gpc_level.sv
module gpc_level
  import gpc_tree_pkg::*;
#(
  parameter int R_IN = 8,
  parameter int RW   = 11,
  parameter bit REG  = 1'b1,
  localparam int R_OUT = rows_next(R_IN)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_vld,
  input  logic [R_IN-1:0][RW-1:0]  in_rows,
  output logic                     out_vld,
  output logic [R_OUT-1:0][RW-1:0] out_rows
);

  localparam int FULL  = R_IN / CELL_COL_BITS;
  localparam int REM   = R_IN % CELL_COL_BITS;
  localparam int GRPS  = FULL + ((REM >= 3) ? 1 : 0);
  localparam int PASS  = (REM >= 3) ? 0 : REM;
  localparam int NCELL = (RW + 1) / 2;

  logic [CELL_OUT_W-1:0]    cell_cnt [GRPS][NCELL];
  logic [R_OUT-1:0][RW-1:0] nxt;

  // one strip of cells per row group, one cell per column pair
  for (genvar g = 0; g < GRPS; g++) begin : g_grp
    localparam int USED = (g < FULL) ? CELL_COL_BITS : REM;
    for (genvar m = 0; m < NCELL; m++) begin : g_col
      logic [CELL_COL_BITS-1:0] lo;
      logic [CELL_COL_BITS-1:0] hi;
      for (genvar k = 0; k < CELL_COL_BITS; k++) begin : g_bit
        if (k < USED) begin : g_lo_on
          assign lo[k] = in_rows[CELL_COL_BITS*g + k][2*m];
        end else begin : g_lo_off
          assign lo[k] = 1'b0;
        end
        if (k < USED && (2*m + 1) < RW) begin : g_hi_on
          assign hi[k] = in_rows[CELL_COL_BITS*g + k][2*m + 1];
        end else begin : g_hi_off
          assign hi[k] = 1'b0;
        end
      end
      gpc_cell u_cell (
        .lo_bits (lo),
        .hi_bits (hi),
        .count   (cell_cnt[g][m])
      );
    end
  end

  // even column pairs land in one row, odd pairs in the other
  always_comb begin
    nxt = '0;
    for (int g = 0; g < GRPS; g++) begin
      for (int m = 0; m < NCELL; m++) begin
        for (int b = 0; b < CELL_OUT_W; b++) begin
          if (2*m + b < RW) nxt[2*g + (m % 2)][2*m + b] = cell_cnt[g][m][b];
        end
      end
    end
    for (int p = 0; p < PASS; p++) begin
      nxt[2*GRPS + p] = in_rows[CELL_COL_BITS*FULL + p];
    end
  end

  // row totals, used only by the checks below
  logic [RW-1:0] in_total;
  logic [RW-1:0] out_total;
  always_comb begin
    in_total = '0;
    for (int r = 0; r < R_IN; r++) in_total = in_total + in_rows[r];
    out_total = '0;
    for (int r = 0; r < R_OUT; r++) out_total = out_total + out_rows[r];
  end

  if (REG) begin : g_reg
    logic                     vld_q;
    logic [R_OUT-1:0][RW-1:0] rows_q;
    always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= in_vld;
      if (in_vld) rows_q <= nxt;
    end
    assign out_vld  = vld_q;
    assign out_rows = rows_q;

    // R2: registered rows carry the total of the rows captured
    a_r2_sum_kept_reg: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> out_total == $past(in_total));
    // R6: strobe advances by exactly one cycle
    a_r6_valid_step: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> out_vld == $past(in_vld));
  end else begin : g_byp
    assign out_vld  = in_vld;
    assign out_rows = nxt;

    // R2: transparent level keeps the total in the same cycle
    a_r2_sum_kept_byp: assert property (@(posedge clk) disable iff (rst)
      in_vld |-> out_total == in_total);
    // R8: transparent level passes the strobe unchanged
    a_r8_valid_through: assert property (@(posedge clk) disable iff (rst)
      out_vld == in_vld);
  end

endmodule

// File: rtl/gpc_final_adder.sv
module gpc_final_adder #(
  parameter int RW = 11
) (
  input  logic [1:0][RW-1:0] rows,
  output logic [RW-1:0]      total
);

  assign total = rows[0] + rows[1];

endmodule

// File: rtl/gpc_adder_tree.sv
module gpc_adder_tree
  import gpc_tree_pkg::*;
#(
  parameter int                 N_OPS   = 8,
  parameter int                 OP_W    = 8,
  parameter logic [MAX_LVL-1:0] LVL_REG = '1,
  localparam int RW = OP_W + $clog2(N_OPS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_vld,
  input  logic [N_OPS*OP_W-1:0] in_ops,
  output logic                  out_vld,
  output logic [RW-1:0]         out_sum
);

  localparam int NL = tree_levels(N_OPS);

  function automatic int count_regs(input logic [MAX_LVL-1:0] m, input int nl);
    int c;
    c = 0;
    for (int i = 0; i < nl; i++) if (m[i]) c++;
    return c;
  endfunction

  localparam int LAT = count_regs(LVL_REG, NL);
  localparam longint MAX_TOTAL = longint'(N_OPS) * ((longint'(1) << OP_W) - 1);

  logic [N_OPS-1:0][RW-1:0] heap [NL+1];
  logic [NL:0]              vld;

  assign vld[0] = in_vld;

  for (genvar o = 0; o < N_OPS; o++) begin : g_op
    assign heap[0][o] = RW'(in_ops[o*OP_W +: OP_W]);
  end

  for (genvar l = 0; l < NL; l++) begin : g_lvl
    localparam int RI = rows_at(N_OPS, l);
    localparam int RO = rows_at(N_OPS, l + 1);
    gpc_level #(
      .R_IN (RI),
      .RW   (RW),
      .REG  (LVL_REG[l])
    ) u_lvl (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (vld[l]),
      .in_rows  (heap[l][RI-1:0]),
      .out_vld  (vld[l+1]),
      .out_rows (heap[l+1][RO-1:0])
    );
    if (RO < N_OPS) begin : g_pad
      assign heap[l+1][N_OPS-1:RO] = '0;
    end
  end

  gpc_final_adder #(.RW(RW)) u_cpa (
    .rows  (heap[NL][1:0]),
    .total (out_sum)
  );

  assign out_vld = vld[NL];

  // R1: a valid result never exceeds the largest possible total
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> longint'(out_sum) <= MAX_TOTAL);

  if (LAT > 0) begin : g_rst_chk
    // R7: nothing emerges in the cycle after reset
    a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_vld);
  end

endmodule

// File: tb/test_gpc_adder_tree.sv
module test_gpc_adder_tree;

  localparam int CLK_NS = 10;
  localparam int N      = 8;
  localparam int W      = 8;
  localparam int RW     = W + $clog2(N);
  localparam int P_LAT  = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_vld = 1'b0;
  logic [N*W-1:0] in_ops = '0;
  logic           p_vld, c_vld;
  logic [RW-1:0]  p_sum, c_sum;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int    total;
    int    issue;
    string tag;
  } exp_t;
  exp_t q_p[$];

  gpc_adder_tree #(.N_OPS(N), .OP_W(W), .LVL_REG(8'hFF)) i_gpc_adder_tree (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_ops(in_ops),
    .out_vld(p_vld), .out_sum(p_sum)
  );

  gpc_adder_tree #(.N_OPS(N), .OP_W(W), .LVL_REG(8'h00)) i_gpc_adder_tree_comb (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_ops(in_ops),
    .out_vld(c_vld), .out_sum(c_sum)
  );

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int total_of(input logic [N*W-1:0] ops);
    int s;
    s = 0;
    for (int o = 0; o < N; o++) s += int'(ops[o*W +: W]);
    return s;
  endfunction

  // driver: presents one set, queues the pipelined expectation, checks the
  // combinational build in the same cycle
  task automatic drive(input logic [N*W-1:0] ops, input string tag, input bit track);
    int t;
    @(negedge clk);
    in_ops = ops;
    in_vld = 1'b1;
    t = total_of(ops);
    if (track) q_p.push_back('{t, cyc, tag});
    #1;
    check(c_vld == 1'b1, "R8", "comb valid", int'(c_vld), 1);
    check(int'(c_sum) == t, {tag, "/R8"}, "comb sum", int'(c_sum), t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      #1;
      check(c_vld == 1'b0, "R6", "comb valid idle", int'(c_vld), 0);
    end
  endtask

  // monitor: pops the scoreboard whenever the pipelined build emits
  always begin
    @(negedge clk);
    #1;
    if (!rst && p_vld) begin
      if (q_p.size() == 0) begin
        check(1'b0, "R6", "unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = q_p.pop_front();
        check(int'(p_sum) == e.total, {e.tag, "/R1"}, "pipe sum", int'(p_sum), e.total);
        check(cyc - e.issue == P_LAT, "R5", "pipe latency", cyc - e.issue, P_LAT);
      end
    end
  end

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    check(1'b0, "WATCHDOG", "run did not end", 0, 1);
    finish_run();
  end

  initial begin
    logic [N*W-1:0] v;
    logic [RW-1:0]  held;

    repeat (3) @(negedge clk);
    #1;
    check(p_vld == 1'b0, "R7", "pipe valid in reset", int'(p_vld), 0);
    check(c_vld == 1'b0, "R7", "comb valid in reset", int'(c_vld), 0);
    @(negedge clk);
    rst = 1'b0;

    drive('0, "R1", 1'b1);
    drive('1, "R1", 1'b1);                       // 8 x 255 = 2040, no overflow
    v = '0;
    for (int o = 0; o < N; o++) v[o*W +: W] = 8'h03;
    drive(v, "R3", 1'b1);                        // both weights in every low cell
    for (int o = 0; o < N; o++) v[o*W +: W] = (o % 2 == 0) ? 8'hAA : 8'h55;
    drive(v, "R3", 1'b1);
    v = '0; v[0 +: W] = 8'hFF;
    drive(v, "R4", 1'b1);                        // single operand in full group
    v = '0;
    for (int o = 5; o < N; o++) v[o*W +: W] = 8'hFF;
    drive(v, "R4", 1'b1);                        // only the group of three
    v = '0; v[7*W +: W] = 8'h81;
    drive(v, "R4", 1'b1);
    idle(3);

    for (int i = 0; i < 40; i++) begin           // back-to-back random sets
      drive({$urandom, $urandom}, "R2", 1'b1);
      if (i % 9 == 8) idle(1);
    end
    idle(4);
    check(q_p.size() == 0, "R6", "results pending", q_p.size(), 0);

    // R9: idle operands must not disturb the registered tree
    held = p_sum;
    @(negedge clk);
    in_ops = {$urandom, $urandom};
    in_vld = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      check(p_vld == 1'b0, "R9", "pipe valid idle", int'(p_vld), 0);
      check(p_sum == held, "R9", "pipe sum held", int'(p_sum), int'(held));
    end

    // R7: reset while a set is inside the pipeline
    drive({$urandom, $urandom}, "R7", 1'b0);
    @(negedge clk);
    in_vld = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1;
      check(p_vld == 1'b0, "R7", "dropped set emerged", int'(p_vld), 0);
    end

    drive('1, "R7", 1'b1);                       // recovery after reset
    idle(4);
    check(q_p.size() == 0, "R6", "results pending at end", q_p.size(), 0);
    finish_run();
  end

endmodule